// File: doc/BRIEF.md
# Token-Passed Sparse Channel Readout Sequencer

This block drains the digitized results of a multi-channel front end onto an 8-bit parallel bus that several chips share. Each of its 128 channels holds a code and a hit flag, loaded through a simple write port. On readout, only the channels that are selected are sent: a channel is selected when its hit flag is set, or when the read-all mode is on. Each selected channel goes out as a pair of words: first its channel number, then its code. Word slots alternate with idle cycles, so the sustained word rate is half the clock rate.

Bus ownership moves from chip to chip on a daisy-chained token. A pulse on `tok_in` grants this chip the bus. The chip then enables its driver, streams its pairs and releases the driver. One word slot after the last pair it pulses `tok_out` to hand the bus on, or it does so straight away if it has nothing to send. Once it has passed the token, the chip ignores any further token pulses until `rd_start`. This guard stops a late token from causing a second readout. `rd_start` also aborts a readout in progress and rewinds the scan to channel 0.

The output is a valid/ready stream. A word is presented with `bus_valid` high and is taken in a cycle where `bus_ready` is also high. While `bus_ready` is low, the word and its valid flag hold unchanged. After a word is taken, at least one idle cycle follows before the next word.

Top module: `sparse_rdo_top`

## Requirements
- R1: While reset is asserted and in the cycle after it is released, `bus_valid`, `bus_oe` and `tok_out` are low and `bus_data` is zero.
- R2: Each emitted channel is sent as an ID word followed by a data word. The ID word carries the channel number zero-extended in bits [6:0], and the data word carries the stored code. After a word is accepted, `bus_valid` is low for exactly one cycle before the next word. With `bus_ready` held high, words therefore appear on alternate cycles.
- R3: While `bus_valid` is high and `bus_ready` is low, `bus_valid` stays high and `bus_data` is unchanged in the next cycle.
- R4: Without read-all, only channels whose hit flag is 1 are emitted. They are emitted in strictly ascending channel order, and no channel is emitted twice in one readout.
- R5: With `read_all` high, all 128 channels are emitted in ascending order, whatever their hit flags.
- R6: `tok_out` is a one-cycle pulse. It is high in the second cycle after the cycle in which the last data word was accepted, and `bus_oe` is low in that cycle.
- R7: If no channel is selected when `tok_in` is sampled high, `tok_out` pulses in the next cycle and no word is emitted.
- R8: `bus_oe` is high from the first ID word through the idle cycle after the last data word, and low otherwise. `bus_valid` is never high while `bus_oe` is low.
- R9: After the token has been passed, further `tok_in` pulses produce no words and no `tok_out` until `rd_start`.
- R10: `rd_start` makes `bus_oe`, `bus_valid` and `tok_out` low in the next cycle and discards any readout in progress. The next token replays from channel 0.
- R11: A write with `wr_en` high stores `wr_code` and `wr_hit` for channel `wr_ch`, and the stored values take effect from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Backend clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Channel write strobe |
| wr_ch | input | 7 | Channel number to write |
| wr_code | input | 8 | Digitized code to store |
| wr_hit | input | 1 | Hit flag to store |
| read_all | input | 1 | Select every channel regardless of hit flags |
| rd_start | input | 1 | Start a new readout: rewind scan, drop token |
| tok_in | input | 1 | Token grant pulse from the previous chip |
| bus_data | output | 8 | Shared bus word (ID or code) |
| bus_valid | output | 1 | Word on `bus_data` is valid |
| bus_ready | input | 1 | Bus accepts the current word |
| bus_oe | output | 1 | Bus driver enable, high while the token is held |
| tok_out | output | 1 | Token pass pulse to the next chip |

## Verification
The embedded properties check these rules on every cycle:
- the stream holds steady under back-pressure;
- an accepted word is always followed by one idle cycle;
- `bus_valid` stays inside `bus_oe`;
- `tok_out` is a single pulse while the driver is off;
- channel IDs strictly increase within a readout;
- the post-pass state stays locked against late tokens;
- writes take effect in the next cycle.

Other properties are only visible through whole scenarios, which the bench's queue-based reference model compares cycle by cycle:
- the selected set and the data values;
- the exact slot in which the token leaves;
- the immediate pass when nothing is selected;
- read-all covering all 128 channels, including channels 0 and 127;
- replay from channel 0 after an aborted readout.

// File: rtl/rdo_pkg.sv
package rdo_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_ID,
    S_GAP1,
    S_DAT,
    S_GAP2,
    S_PASS,
    S_DONE
  } seq_state_t;
endpackage

// File: rtl/chan_store.sv
module chan_store #(
  parameter int NCH = 128,
  parameter int DW  = 8,
  localparam int CHW = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [CHW-1:0] wr_ch,
  input  logic [DW-1:0]  wr_code,
  input  logic           wr_hit,
  input  logic           read_all,
  input  logic [CHW-1:0] rd_ch,
  output logic [NCH-1:0] sel,
  output logic [DW-1:0]  rd_code
);
  logic [DW-1:0]  code_q [NCH];
  logic [NCH-1:0] hit_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_q <= '0;
      for (int i = 0; i < NCH; i++) code_q[i] <= '0;
    end else if (wr_en) begin
      code_q[wr_ch] <= wr_code;
      hit_q[wr_ch]  <= wr_hit;
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_sel
    assign sel[g] = hit_q[g] | read_all;
  end

  assign rd_code = code_q[rd_ch];

  // R11
  write_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (hit_q[$past(wr_ch)] == $past(wr_hit)) && (code_q[$past(wr_ch)] == $past(wr_code)));
endmodule

// File: rtl/next_sel_finder.sv
module next_sel_finder #(
  parameter int NCH = 128,
  localparam int CHW = $clog2(NCH)
) (
  input  logic [NCH-1:0] sel,
  input  logic [CHW:0]   start,
  output logic           found,
  output logic [CHW-1:0] idx
);
  logic [NCH-1:0] cand;

  for (genvar g = 0; g < NCH; g++) begin : g_cand
    assign cand[g] = sel[g] && (g >= int'(start));
  end

  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (cand[i]) begin
        found = 1'b1;
        idx   = CHW'(i);
      end
    end
  end
endmodule

// File: rtl/rdo_sequencer.sv
module rdo_sequencer
  import rdo_pkg::*;
#(
  parameter int NCH = 128,
  parameter int DW  = 8,
  localparam int CHW = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           rd_start,
  input  logic           tok_in,
  input  logic           bus_ready,
  input  logic           found,
  input  logic [CHW-1:0] nxt_idx,
  input  logic [DW-1:0]  rd_code,
  output logic [CHW:0]   start,
  output logic [CHW-1:0] cur_ch,
  output logic [DW-1:0]  bus_data,
  output logic           bus_valid,
  output logic           bus_oe,
  output logic           tok_out
);
  seq_state_t     state_q, state_d;
  logic [CHW-1:0] ch_q, ch_d;

  assign start  = (state_q == S_GAP2) ? ({1'b0, ch_q} + 1'b1) : '0;
  assign cur_ch = ch_q;

  always_comb begin
    state_d = state_q;
    ch_d    = ch_q;
    if (rd_start) begin
      state_d = S_IDLE;
      ch_d    = '0;
    end else begin
      unique case (state_q)
        S_IDLE: if (tok_in) begin
          if (found) begin
            state_d = S_ID;
            ch_d    = nxt_idx;
          end else begin
            state_d = S_PASS;
          end
        end
        S_ID:   if (bus_ready) state_d = S_GAP1;
        S_GAP1: state_d = S_DAT;
        S_DAT:  if (bus_ready) state_d = S_GAP2;
        S_GAP2: if (found) begin
          state_d = S_ID;
          ch_d    = nxt_idx;
        end else begin
          state_d = S_PASS;
        end
        S_PASS: state_d = S_DONE;
        S_DONE: state_d = S_DONE;
        default: state_d = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      ch_q    <= '0;
    end else begin
      state_q <= state_d;
      ch_q    <= ch_d;
    end
  end

  assign bus_valid = (state_q == S_ID) || (state_q == S_DAT);
  assign bus_oe    = (state_q == S_ID) || (state_q == S_GAP1) ||
                     (state_q == S_DAT) || (state_q == S_GAP2);
  assign tok_out   = (state_q == S_PASS);

  always_comb begin
    bus_data = '0;
    if (state_q == S_ID)       bus_data = DW'(ch_q);
    else if (state_q == S_DAT) bus_data = rd_code;
  end

  // Channel-order tracker used by the ordering property below
  logic [CHW-1:0] last_ch_q;
  logic           have_last_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_ch_q   <= '0;
      have_last_q <= 1'b0;
    end else if (rd_start) begin
      have_last_q <= 1'b0;
    end else if (state_q == S_ID && bus_ready) begin
      last_ch_q   <= ch_q;
      have_last_q <= 1'b1;
    end
  end

  // R3
  hold_under_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_ready && !rd_start) |=> (bus_valid && $stable(bus_data)));
  // R2
  gap_after_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_ready) |=> !bus_valid);
  // R8
  valid_inside_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |-> bus_oe);
  // R6
  tok_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tok_out |-> (!bus_oe ##1 !tok_out));
  // R4
  ascending_id_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_ID && have_last_q) |-> (ch_q > last_ch_q));
  // R9
  locked_after_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_DONE && !rd_start) |=> (!bus_oe && !tok_out));
  // R10
  start_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_start |=> (!bus_oe && !bus_valid && !tok_out));
endmodule

// File: rtl/sparse_rdo_top.sv
module sparse_rdo_top #(
  parameter int NCH = 128,
  parameter int DW  = 8,
  localparam int CHW = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [CHW-1:0] wr_ch,
  input  logic [DW-1:0]  wr_code,
  input  logic           wr_hit,
  input  logic           read_all,
  input  logic           rd_start,
  input  logic           tok_in,
  output logic [DW-1:0]  bus_data,
  output logic           bus_valid,
  input  logic           bus_ready,
  output logic           bus_oe,
  output logic           tok_out
);
  logic [NCH-1:0] sel;
  logic [DW-1:0]  rd_code;
  logic [CHW:0]   start;
  logic [CHW-1:0] cur_ch, nxt_idx;
  logic           found;

  chan_store #(.NCH(NCH), .DW(DW)) store_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ch(wr_ch), .wr_code(wr_code),
    .wr_hit(wr_hit), .read_all(read_all), .rd_ch(cur_ch), .sel(sel), .rd_code(rd_code)
  );

  next_sel_finder #(.NCH(NCH)) find_i (
    .sel(sel), .start(start), .found(found), .idx(nxt_idx)
  );

  rdo_sequencer #(.NCH(NCH), .DW(DW)) seq_i (
    .clk(clk), .rst_n(rst_n), .rd_start(rd_start), .tok_in(tok_in),
    .bus_ready(bus_ready), .found(found), .nxt_idx(nxt_idx), .rd_code(rd_code),
    .start(start), .cur_ch(cur_ch), .bus_data(bus_data), .bus_valid(bus_valid),
    .bus_oe(bus_oe), .tok_out(tok_out)
  );
endmodule

// File: tb/sparse_rdo_top_tb_top.sv
module sparse_rdo_top_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [6:0] wr_ch = '0;
  logic [7:0] wr_code = '0;
  logic       wr_hit = 1'b0;
  logic       read_all = 1'b0;
  logic       rd_start = 1'b0;
  logic       tok_in = 1'b0;
  logic       bus_ready = 1'b1;
  logic [7:0] bus_data;
  logic       bus_valid, bus_oe, tok_out;

  always #10 clk = ~clk;

  sparse_rdo_top dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ch(wr_ch), .wr_code(wr_code),
    .wr_hit(wr_hit), .read_all(read_all), .rd_start(rd_start), .tok_in(tok_in),
    .bus_data(bus_data), .bus_valid(bus_valid), .bus_ready(bus_ready),
    .bus_oe(bus_oe), .tok_out(tok_out)
  );

  int vectors = 0;
  int fails   = 0;
  bit summary_done = 0;
  string cur_req = "R1";

  // Reference model state
  int m_code[128];
  bit m_hit[128];
  int q[$];
  bit m_held = 0, m_gap = 0, m_done = 0, m_tok = 0;

  task automatic compare();
    bit   ev;
    int   ed;
    ev = m_held && !m_gap;
    ed = ev ? q[0] : 0;
    vectors++;
    if (bus_valid !== ev || bus_data !== 8'(ed) || bus_oe !== m_held || tok_out !== m_tok) begin
      fails++;
      $display("FAIL %s: got valid=%0b data=%0d oe=%0b tok=%0b exp valid=%0b data=%0d oe=%0b tok=%0b",
               cur_req, bus_valid, bus_data, bus_oe, tok_out, ev, ed, m_held, m_tok);
    end
  endtask

  task automatic model_step();
    if (!rst_n) begin
      for (int i = 0; i < 128; i++) begin m_code[i] = 0; m_hit[i] = 0; end
      q.delete(); m_held = 0; m_gap = 0; m_done = 0; m_tok = 0;
      return;
    end
    if (rd_start) begin
      q.delete(); m_held = 0; m_gap = 0; m_done = 0; m_tok = 0;
    end else if (m_tok) begin
      m_tok = 0; m_done = 1;
    end else if (m_held) begin
      if (!m_gap) begin
        if (bus_ready) begin void'(q.pop_front()); m_gap = 1; end
      end else if (q.size() == 0) begin
        m_held = 0; m_gap = 0; m_tok = 1;
      end else begin
        m_gap = 0;
      end
    end else if (!m_done && tok_in) begin
      for (int i = 0; i < 128; i++)
        if (m_hit[i] || read_all) begin q.push_back(i); q.push_back(m_code[i]); end
      if (q.size() == 0) m_tok = 1;
      else begin m_held = 1; m_gap = 0; end
    end
    if (wr_en) begin m_code[wr_ch] = wr_code; m_hit[wr_ch] = wr_hit; end
  endtask

  task automatic tick();
    compare();
    model_step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic wr(int ch, int code, bit hit);
    wr_en = 1; wr_ch = 7'(ch); wr_code = 8'(code); wr_hit = hit;
    tick();
    wr_en = 0;
  endtask

  task automatic token();
    tok_in = 1; tick(); tok_in = 0;
  endtask

  task automatic restart();
    rd_start = 1; tick(); rd_start = 0;
  endtask

  task automatic finish_run();
    if (!summary_done) begin
      summary_done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 20);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    @(negedge clk);
    cur_req = "R1";
    run(3);
    rst_n = 1;
    run(3);

    // R11: load codes and hit flags, checked through the readout below
    cur_req = "R11";
    wr(3, 8'h5a, 1); wr(10, 8'hc3, 1); wr(127, 8'h7e, 1); wr(40, 8'h11, 0);
    run(2);

    // R2 R4 R6 R8: sparse readout with ready held high
    cur_req = "R4";
    token();
    run(20);

    // R9: late token after pass must not cause a second readout
    cur_req = "R9";
    token();
    run(10);

    // R3: back-pressure pattern
    cur_req = "R3";
    restart();
    tok_in = 1;
    for (int i = 0; i < 40; i++) begin
      bus_ready = (i % 3 == 2);
      tick();
      tok_in = 0;
    end
    bus_ready = 1;
    run(10);

    // R10: abort mid-readout and replay from channel 0
    cur_req = "R10";
    restart();
    wr(0, 8'h99, 1);
    token();
    run(3);
    restart();
    run(2);
    token();
    run(25);

    // R7: no hits selected
    cur_req = "R7";
    restart();
    wr(0, 0, 0); wr(3, 0, 0); wr(10, 0, 0); wr(127, 0, 0);
    token();
    run(5);

    // R5: read-all covers every channel, including 0 and 127
    cur_req = "R5";
    for (int i = 0; i < 128; i += 17) wr(i, (i * 7 + 1) & 255, 0);
    wr(127, 8'hf0, 0);
    read_all = 1;
    restart();
    token();
    run(128 * 4 + 10);
    read_all = 0;

    // R6 R2: boundary channels 0 and 127 only, with a stall on the last word
    cur_req = "R6";
    wr(0, 8'h01, 1); wr(127, 8'hfe, 1);
    restart();
    token();
    run(6);
    bus_ready = 0;
    run(3);
    bus_ready = 1;
    run(8);

    finish_run();
  end
endmodule